// File: doc/BRIEF.md
# Prescaled UART Bit-Rate Generator

This block produces the timing pulses that a UART shifter needs. It derives them from a reference clock. An optional fixed prescaler divides the reference by eight. A programmable clock divisor then produces a sample-rate pulse, and a programmable oversampling divider turns every (divider + 1) sample pulses into one bit-rate pulse. The resulting bit rate is the selected clock divided by the product of the clock divisor and the oversampling divider plus one.

Software-side logic programs three values through a single write port: a frame/mode byte, the clock divisor and the oversampling divider. A divisor write below its legal minimum is dropped silently. An accepted write to any of the three registers restarts every counter, so the next pulses follow the new settings from a known phase. From the mode byte the block also derives the length of one character in bit periods and in sample periods, for use by the shifter and by timeout logic.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset the clock divisor is 0x28B, the oversampling divider is 0xF and the mode byte is 0, which gives a character length of 12 bits and 192 sample periods.
- R2: With wrSel = 1, a write of a nonzero 32-bit value stores its low 16 bits as the clock divisor. A write of zero changes nothing and does not restart the counters. A stored divisor of zero acts as 65536.
- R3: With wrSel = 2, a write of a 32-bit value of at least 4 stores its low 8 bits as the oversampling divider. A smaller value changes nothing and does not restart the counters.
- R4: With mode bit 0 clear, sampleTick is a one-cycle pulse that repeats every D cycles, where D is the clock divisor. After an accepted register write, the first pulse falls in the D-th cycle after the write edge.
- R5: With mode bit 0 set, every divisor count waits for eight reference cycles. sampleTick then repeats every 8·D cycles, and the first pulse after a restart falls in cycle 8·D.
- R6: bitTick pulses together with sampleTick on every (V+1)-th sample pulse, where V is the oversampling divider. The first bitTick after a restart falls in cycle (V+1)·D when the prescaler is off.
- R7: An accepted write to the mode register (wrSel = 0, low 8 bits kept), the clock divisor or the oversampling divider clears the prescaler, divisor and oversampling counters at that edge. A write with wrSel = 3 has no effect.
- R8: charBits = 1 start bit + data bits (6 when mode[2:1] = 3, 7 when mode[2:1] = 2, otherwise 8) + 1 parity bit when mode[5:3] is 0 or 1 + stop bits (1 when mode[7:6] = 3, otherwise 2).
- R9: charSamples equals charBits × (V + 1) and follows mode and oversampling changes combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 mode, 1 clock divisor, 2 oversampling divider, 3 none |
| wrData | input | 32 | Write value |
| sampleTick | output | 1 | One-cycle pulse at the sample rate |
| bitTick | output | 1 | One-cycle pulse at the bit rate |
| charBits | output | 4 | Bit periods per character |
| charSamples | output | 13 | Sample periods per character |
| clkDivOut | output | 16 | Clock divisor in effect |
| ovsDivOut | output | 8 | Oversampling divider in effect |

## Verification
The assertions check four things on every cycle. The divisor and oversampling counters stay inside their programmed ranges. Every accepted write clears the counters. A sample pulse in prescaled mode is never followed by another on the next cycle. Illegal divisor writes leave the stored value untouched, and charBits stays within 7 to 12. Only the bench scenarios can show the exact pulse spacing and first-pulse latency for a given divisor setting, the low-bit truncation of wide writes, and the fact that a rejected or unselected write leaves the running phase undisturbed. The bench also covers the zero-divisor wrap to 65536 and the character-length decoding over a set of mode bytes.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_CLKDIV = 2'd1,
    SEL_OVSDIV = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // strobes and levels passed from control to the counter datapath
  typedef struct packed {
    logic restart;
    logic prescaleOn;
  } ctlCmd_t;

endpackage

// File: rtl/baudgen_ctl.sv
module baudgen_ctl
  import baudgen_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 16,
  parameter int OVS_W   = 8,
  parameter int MODE_W  = 8,
  parameter int DIV_RST = 'h28B,
  parameter int OVS_RST = 'hF,
  parameter int OVS_MIN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DIV_W-1:0]  clkDiv,
  output logic [OVS_W-1:0]  ovsDiv,
  output logic [MODE_W-1:0] modeReg,
  output ctlCmd_t           cmd
);

  regSel_e sel;
  logic    divAccept;
  logic    ovsAccept;
  logic    modeAccept;

  assign sel        = regSel_e'(wrSel);
  assign divAccept  = wrEn && (sel == SEL_CLKDIV) && (wrData != '0);
  assign ovsAccept  = wrEn && (sel == SEL_OVSDIV) && (wrData >= DATA_W'(OVS_MIN));
  assign modeAccept = wrEn && (sel == SEL_MODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkDiv  <= DIV_W'(DIV_RST);
      ovsDiv  <= OVS_W'(OVS_RST);
      modeReg <= '0;
    end else begin
      if (divAccept)  clkDiv  <= wrData[DIV_W-1:0];
      if (ovsAccept)  ovsDiv  <= wrData[OVS_W-1:0];
      if (modeAccept) modeReg <= wrData[MODE_W-1:0];
    end
  end

  assign cmd.restart    = divAccept | ovsAccept | modeAccept;
  assign cmd.prescaleOn = modeReg[0];

  AST_DIV_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd1 && wrData == '0) |=> $stable(clkDiv)); // R2

  AST_OVS_LOW_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2 && wrData < DATA_W'(OVS_MIN)) |=> $stable(ovsDiv)); // R3

endmodule

// File: rtl/baudgen_dp.sv
module baudgen_dp
  import baudgen_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OVS_W    = 8,
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlCmd_t          cmd,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [OVS_W-1:0] ovsDiv,
  output logic             sampleTick,
  output logic             bitTick
);

  logic             preEn;
  logic [DIV_W-1:0] divCnt;
  logic [OVS_W-1:0] ovsCnt;
  logic             divLast;
  logic             ovsLast;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PRE_W = $clog2(PRESCALE);
      logic [PRE_W-1:0] preCnt;
      logic             preWrap;

      assign preWrap = (preCnt == PRE_W'(PRESCALE - 1));

      always_ff @(posedge clk) begin
        if (!rstN || cmd.restart) preCnt <= '0;
        else if (preWrap)         preCnt <= '0;
        else                      preCnt <= preCnt + 1'b1;
      end

      assign preEn = cmd.prescaleOn ? preWrap : 1'b1;
    end else begin : g_nopre
      assign preEn = 1'b1;
    end
  endgenerate

  // a stored divisor of zero compares against all ones: a full wrap
  assign divLast    = (divCnt == clkDiv - DIV_W'(1));
  assign sampleTick = preEn && divLast;
  assign ovsLast    = (ovsCnt == ovsDiv);
  assign bitTick    = sampleTick && ovsLast;

  always_ff @(posedge clk) begin
    if (!rstN || cmd.restart) divCnt <= '0;
    else if (preEn)           divCnt <= divLast ? '0 : divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.restart) ovsCnt <= '0;
    else if (sampleTick)      ovsCnt <= ovsLast ? '0 : ovsCnt + 1'b1;
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (clkDiv != '0) |-> (divCnt < clkDiv)); // R4

  AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.prescaleOn && sampleTick) |=> (!sampleTick || !cmd.prescaleOn)); // R5

  AST_OVS_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ovsCnt <= ovsDiv); // R6

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (divCnt == '0 && ovsCnt == '0)); // R7

endmodule

// File: rtl/baudgen_frame.sv
module baudgen_frame #(
  parameter int MODE_W = 8,
  parameter int OVS_W  = 8,
  parameter int BITS_W = 4,
  parameter int SAMP_W = BITS_W + OVS_W + 1
) (
  input  logic [MODE_W-1:0] modeReg,
  input  logic [OVS_W-1:0]  ovsDiv,
  output logic [BITS_W-1:0] charBits,
  output logic [SAMP_W-1:0] charSamples
);

  logic [BITS_W-1:0] dataBits;
  logic [BITS_W-1:0] parityBits;
  logic [BITS_W-1:0] stopBits;
  logic [OVS_W:0]    ovsSpan;

  always_comb begin
    unique case (modeReg[2:1])
      2'd3:    dataBits = BITS_W'(6);
      2'd2:    dataBits = BITS_W'(7);
      default: dataBits = BITS_W'(8);
    endcase
    parityBits = (modeReg[5:3] <= 3'd1) ? BITS_W'(1) : BITS_W'(0);
    stopBits   = (modeReg[7:6] == 2'd3) ? BITS_W'(1) : BITS_W'(2);
  end

  assign charBits    = BITS_W'(1) + dataBits + parityBits + stopBits;
  assign ovsSpan     = {1'b0, ovsDiv} + 1'b1;
  assign charSamples = SAMP_W'(charBits) * SAMP_W'(ovsSpan);

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baudgen_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 16,
  parameter int OVS_W    = 8,
  parameter int MODE_W   = 8,
  parameter int PRESCALE = 8,
  parameter int DIV_RST  = 'h28B,
  parameter int OVS_RST  = 'hF,
  parameter int OVS_MIN  = 4,
  parameter int BITS_W   = 4,
  parameter int SAMP_W   = BITS_W + OVS_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              sampleTick,
  output logic              bitTick,
  output logic [BITS_W-1:0] charBits,
  output logic [SAMP_W-1:0] charSamples,
  output logic [DIV_W-1:0]  clkDivOut,
  output logic [OVS_W-1:0]  ovsDivOut
);

  ctlCmd_t           cmd;
  logic [DIV_W-1:0]  clkDiv;
  logic [OVS_W-1:0]  ovsDiv;
  logic [MODE_W-1:0] modeReg;

  baudgen_ctl #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .OVS_W(OVS_W), .MODE_W(MODE_W),
    .DIV_RST(DIV_RST), .OVS_RST(OVS_RST), .OVS_MIN(OVS_MIN)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .clkDiv(clkDiv), .ovsDiv(ovsDiv), .modeReg(modeReg), .cmd(cmd)
  );

  baudgen_dp #(
    .DIV_W(DIV_W), .OVS_W(OVS_W), .PRESCALE(PRESCALE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .clkDiv(clkDiv), .ovsDiv(ovsDiv),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );

  baudgen_frame #(
    .MODE_W(MODE_W), .OVS_W(OVS_W), .BITS_W(BITS_W), .SAMP_W(SAMP_W)
  ) i_frame (
    .modeReg(modeReg), .ovsDiv(ovsDiv),
    .charBits(charBits), .charSamples(charSamples)
  );

  assign clkDivOut = clkDiv;
  assign ovsDivOut = ovsDiv;

  AST_CHAR_BITS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (charBits >= BITS_W'(7)) && (charBits <= BITS_W'(12))); // R8

endmodule

// File: tb/test_baud_rate_gen.sv
module test_baud_rate_gen;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd3;
  logic [31:0] wrData = '0;
  logic        sampleTick, bitTick;
  logic [3:0]  charBits;
  logic [12:0] charSamples;
  logic [15:0] clkDivOut;
  logic [7:0]  ovsDivOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_rate_gen i_baud_rate_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .sampleTick(sampleTick), .bitTick(bitTick), .charBits(charBits),
    .charSamples(charSamples), .clkDivOut(clkDivOut), .ovsDivOut(ovsDivOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ends at the negedge right after the write edge (index 1)
  task automatic writeReg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 2'd3; wrData = '0;
  endtask

  task automatic firstPulse(input bit useBit, input int startIdx, output int n);
    n = startIdx;
    while (!(useBit ? bitTick : sampleTick) && n < 100000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic nextPulse(input bit useBit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(useBit ? bitTick : sampleTick) && n < 100000);
  endtask

  function automatic int expBits(input int m);
    int d, data, par, stop;
    d    = (m >> 1) & 3;
    data = (d == 3) ? 6 : (d == 2) ? 7 : 8;
    par  = (((m >> 3) & 7) <= 1) ? 1 : 0;
    stop = (((m >> 6) & 3) == 3) ? 1 : 2;
    return 1 + data + par + stop;
  endfunction

  task automatic testReset();
    check(clkDivOut == 16'h28B, "R1 divisor", clkDivOut, 16'h28B);
    check(ovsDivOut == 8'hF, "R1 oversampling", ovsDivOut, 8'hF);
    check(charBits == 4'd12, "R1 charBits", charBits, 12);
    check(charSamples == 13'd192, "R1 charSamples", charSamples, 192);
  endtask

  task automatic testDivisorWrite();
    int n;
    writeReg(2'd0, 32'h0);
    writeReg(2'd1, 32'd5);
    check(clkDivOut == 16'd5, "R2 accept", clkDivOut, 5);
    writeReg(2'd1, 32'd0);
    check(clkDivOut == 16'd5, "R2 zero ignored", clkDivOut, 5);
    writeReg(2'd1, 32'h12345);
    check(clkDivOut == 16'h2345, "R2 truncation", clkDivOut, 16'h2345);
    writeReg(2'd1, 32'h10000);
    check(clkDivOut == 16'h0, "R2 stored zero", clkDivOut, 0);
    firstPulse(1'b0, 1, n);
    check(n == 65536, "R2 zero acts as 65536", n, 65536);
  endtask

  task automatic testOvsWrite();
    writeReg(2'd2, 32'd9);
    check(ovsDivOut == 8'd9, "R3 accept", ovsDivOut, 9);
    writeReg(2'd2, 32'd3);
    check(ovsDivOut == 8'd9, "R3 below minimum ignored", ovsDivOut, 9);
    writeReg(2'd2, 32'h107);
    check(ovsDivOut == 8'd7, "R3 truncation", ovsDivOut, 7);
    writeReg(2'd2, 32'd4);
    check(ovsDivOut == 8'd4, "R3 minimum accepted", ovsDivOut, 4);
  endtask

  task automatic testSampleTiming();
    int n;
    writeReg(2'd0, 32'h0);
    writeReg(2'd1, 32'd5);
    firstPulse(1'b0, 1, n);
    check(n == 5, "R4 first sample", n, 5);
    nextPulse(1'b0, n);
    check(n == 5, "R4 sample period", n, 5);
    writeReg(2'd1, 32'd1);
    firstPulse(1'b0, 1, n);
    check(n == 1, "R4 divisor one first", n, 1);
    nextPulse(1'b0, n);
    check(n == 1, "R4 divisor one period", n, 1);
  endtask

  task automatic testPrescale();
    int n;
    writeReg(2'd1, 32'd3);
    writeReg(2'd0, 32'h1);
    firstPulse(1'b0, 1, n);
    check(n == 24, "R5 prescaled first", n, 24);
    nextPulse(1'b0, n);
    check(n == 24, "R5 prescaled period", n, 24);
    writeReg(2'd0, 32'h0);
  endtask

  task automatic testBitTick();
    int n;
    writeReg(2'd2, 32'd4);
    writeReg(2'd1, 32'd3);
    firstPulse(1'b1, 1, n);
    check(n == 15, "R6 first bit", n, 15);
    check(sampleTick == 1'b1, "R6 bit with sample", sampleTick, 1);
    nextPulse(1'b1, n);
    check(n == 15, "R6 bit period", n, 15);
  endtask

  task automatic testRestart();
    int n;
    writeReg(2'd1, 32'd4);
    writeReg(2'd2, 32'd4);
    repeat (10) @(negedge clk);
    writeReg(2'd0, 32'h0);
    firstPulse(1'b0, 1, n);
    check(n == 4, "R7 mode write restarts sample", n, 4);
    repeat (7) @(negedge clk);
    writeReg(2'd0, 32'h0);
    firstPulse(1'b1, 1, n);
    check(n == 20, "R7 mode write restarts bit", n, 20);
    // unselected write: phase undisturbed
    writeReg(2'd1, 32'd6);
    writeReg(2'd3, 32'h5);
    firstPulse(1'b0, 3, n);
    check(n == 6, "R7 select 3 no restart", n, 6);
    check(clkDivOut == 16'd6, "R7 select 3 no change", clkDivOut, 6);
    // rejected divisor write: phase undisturbed
    writeReg(2'd1, 32'd6);
    writeReg(2'd1, 32'd0);
    firstPulse(1'b0, 3, n);
    check(n == 6, "R2 rejected write no restart", n, 6);
    writeReg(2'd1, 32'd6);
    writeReg(2'd2, 32'd2);
    firstPulse(1'b0, 3, n);
    check(n == 6, "R3 rejected write no restart", n, 6);
  endtask

  task automatic testFrame();
    int modes[6] = '{32'h00, 32'hE6, 32'h0C, 32'hF8, 32'h02, 32'h92};
    writeReg(2'd2, 32'd7);
    foreach (modes[i]) begin
      writeReg(2'd0, modes[i]);
      check(charBits == 4'(expBits(modes[i])), "R8 charBits", charBits, expBits(modes[i]));
      check(charSamples == 13'(expBits(modes[i]) * 8), "R9 charSamples",
            charSamples, expBits(modes[i]) * 8);
    end
    writeReg(2'd2, 32'd255);
    check(charSamples == 13'(expBits(32'h92) * 256), "R9 follows oversampling",
          charSamples, expBits(32'h92) * 256);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDivisorWrite();
    testOvsWrite();
    testSampleTiming();
    testPrescale();
    testBitTick();
    testRestart();
    testFrame();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule